// File: doc/BRIEF.md
# Programmable-Strength BCH Systematic Encoder

This block appends BCH parity to a serial stream of data bits so that a later decoder can correct up to t bit errors per codeword on flash storage. Arithmetic is over GF(2^13), built from the primitive polynomial x^13+x^4+x^3+x+1. The strength t is chosen per block from the ten even values 2 to 20. For each strength, the generator polynomial is the least common multiple of the minimal polynomials of alpha^1 through alpha^(2t). All ten generators are computed while the design elaborates, and one is selected at run time.

A block starts with a one-cycle strobe that carries t and the number of data bits. If the configuration is legal, t and the length are captured and held until the block ends. The encoder then accepts one data bit per handshake and echoes each bit on the output one cycle later. At the same time it divides the data stream by the selected generator. As soon as the last data bit has left, it shifts out the 13*t-bit remainder with no gap between data and parity, and it marks the final parity bit. An illegal configuration is refused, and an error flag is raised instead.

Top module: `bch_encoder`

## Requirements
- R1: A start strobe seen while idle with a strength that is not one of 2, 4, 6, 8, 10, 12, 14, 16, 18, 20 is refused: on the next cycle `err_o` is 1, `busy_o` is 0 and `in_ready_o` is 0.
- R2: A start strobe with a data length of 0 is refused in the same way as in R1. So is a start strobe where the data length plus 13*t exceeds 8191. A length that makes the sum exactly 8191 is accepted.
- R3: On the cycle after an accepted start, `busy_o` and `in_ready_o` are 1 and `err_o` is 0.
- R4: Each data bit accepted (`in_valid_i` and `in_ready_o` both 1 at a rising edge) appears on `out_bit_o` with `out_valid_o` = 1 in the next cycle, in arrival order.
- R5: The parity is the remainder of D(x)*x^(13t) divided by the generator for t. The first data bit is the highest-order coefficient of D. The parity is 13*t bits long and is sent highest-order coefficient first.
- R6: The first parity bit follows the last data bit in the very next cycle. `out_valid_o` stays 1 through the parity, and `out_last_o` is 1 only together with the final parity bit.
- R7: While idle or while sending parity, `in_ready_o` is 0 and `in_valid_i` produces no output.
- R8: A start strobe seen while a block is in progress is ignored. The running block keeps its strength and length.
- R9: Every codeword (data followed by parity) evaluates to zero at alpha^1 through alpha^(2t).
- R10: A start strobe given in the cycle where `out_last_o` is 1 is accepted.
- R11: After reset, `busy_o`, `in_ready_o`, `out_valid_o`, `out_last_o` and `err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Block start strobe, sampled while idle |
| cfg_t_i | input | 5 | Correction strength t |
| cfg_len_i | input | 13 | Data length of the block in bits |
| in_valid_i | input | 1 | Data bit valid |
| in_bit_i | input | 1 | Data bit |
| in_ready_o | output | 1 | Encoder takes a data bit this cycle |
| out_valid_o | output | 1 | Codeword bit valid |
| out_bit_o | output | 1 | Codeword bit |
| out_last_o | output | 1 | Final bit of the codeword |
| busy_o | output | 1 | Block in progress |
| err_o | output | 1 | Last start strobe was refused |

## Verification
Two pairs of events can land in the same cycle. The first pair is the final parity bit and the acceptance of the next block's start. The bench provokes this by raising the start strobe in exactly the cycle where the last marker is visible. It then expects the new block to be busy one cycle later, and both codewords must match the reference stream bit for bit. The second pair is a data bit and a stray start strobe inside a block. The bench provokes it with a different strength and length, and judges it by requiring the original codeword, at its original length, to come out unchanged and to pass the syndrome check.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;

    localparam int unsigned GF_M   = 13;
    localparam logic [GF_M:0] PRIM = 14'h201B;
    localparam int unsigned MAX_T  = 20;
    localparam int unsigned NSTR   = MAX_T / 2;
    localparam int unsigned MAX_P  = GF_M * MAX_T;
    localparam int unsigned CW_MAX = (1 << GF_M) - 1;
    localparam int unsigned LEN_W  = GF_M;
    localparam int unsigned T_W    = $clog2(MAX_T + 1);
    localparam int unsigned IDX_W  = $clog2(NSTR);
    localparam int unsigned PCNT_W = $clog2(MAX_P + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_PAR  = 2'd2
    } enc_state_e;

    typedef struct packed {
        enc_state_e          st;
        logic [IDX_W-1:0]    idx;
        logic [LEN_W-1:0]    dcnt;
        logic [PCNT_W-1:0]   pcnt;
        logic [MAX_P-1:0]    rem;
        logic                out_vld;
        logic                out_dat;
        logic                out_end;
        logic                err;
    } enc_regs_t;

    // Field multiply, shift-and-add with reduction by the primitive polynomial
    function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a,
                                               input logic [GF_M-1:0] b);
        logic [GF_M-1:0] acc;
        logic [GF_M-1:0] x;
        acc = '0;
        x   = a;
        for (int k = 0; k < int'(GF_M); k++) begin
            if (b[k]) acc = acc ^ x;
            x = x[GF_M-1] ? ((x << 1) ^ PRIM[GF_M-1:0]) : (x << 1);
        end
        return acc;
    endfunction

    // alpha raised to e by square-and-multiply
    function automatic logic [GF_M-1:0] gf_alpha_pow(input int unsigned e);
        logic [GF_M-1:0] r;
        logic [GF_M-1:0] b;
        r = GF_M'(1);
        b = GF_M'(2);
        for (int k = 0; k < int'(GF_M); k++) begin
            if (e[k]) r = gf_mul(r, b);
            b = gf_mul(b, b);
        end
        return r;
    endfunction

    // Binary minimal polynomial of alpha^i: product over its 13 conjugates
    function automatic logic [GF_M:0] min_poly(input int unsigned i);
        logic [GF_M:0][GF_M-1:0] c;
        logic [GF_M-1:0]         beta;
        logic [GF_M:0]           res;
        c    = '0;
        c[0] = GF_M'(1);
        beta = gf_alpha_pow(i);
        for (int j = 0; j < int'(GF_M); j++) begin
            for (int k = int'(GF_M); k >= 1; k--) begin
                c[k] = c[k-1] ^ gf_mul(beta, c[k]);
            end
            c[0] = gf_mul(beta, c[0]);
            beta = gf_mul(beta, beta);
        end
        for (int k = 0; k <= int'(GF_M); k++) res[k] = c[k][0];
        return res;
    endfunction

    function automatic logic [MAX_P:0] poly_mul(input logic [MAX_P:0] g,
                                                input logic [GF_M:0]  m);
        logic [MAX_P:0] r;
        r = '0;
        for (int k = 0; k <= int'(GF_M); k++) begin
            if (m[k]) r = r ^ (g << k);
        end
        return r;
    endfunction

    // Generator for strength t: product of the minimal polynomials of odd powers
    function automatic logic [MAX_P:0] gen_poly(input int unsigned t);
        logic [MAX_P:0] g;
        g = (MAX_P+1)'(1);
        for (int i = 1; i < int'(2 * MAX_T); i += 2) begin
            if (i < int'(2 * t)) g = poly_mul(g, min_poly(i));
        end
        return g;
    endfunction

    // Generator without its leading term, aligned to the top of the register
    function automatic logic [MAX_P-1:0] gen_taps_top(input int unsigned t);
        logic [MAX_P:0] g;
        int unsigned    p;
        g = gen_poly(t);
        p = GF_M * t;
        return g[MAX_P-1:0] << (MAX_P - p);
    endfunction

endpackage

// File: rtl/bch_cfg_check.sv
module bch_cfg_check
    import bch_enc_pkg::*;
(
    input  logic [T_W-1:0]    cfg_t_i,
    input  logic [LEN_W-1:0]  cfg_len_i,
    output logic              ok_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [PCNT_W-1:0] plen_o
);

    logic           t_ok;
    logic [LEN_W:0] total;

    always_comb begin
        t_ok   = (cfg_t_i != '0) && !cfg_t_i[0] && (cfg_t_i <= T_W'(MAX_T));
        idx_o  = IDX_W'((cfg_t_i >> 1) - T_W'(1));
        plen_o = PCNT_W'(cfg_t_i) * PCNT_W'(GF_M);
        total  = {1'b0, cfg_len_i} + (LEN_W+1)'(plen_o);
        ok_o   = t_ok && (cfg_len_i != '0) && (total <= (LEN_W+1)'(CW_MAX));
    end

endmodule

// File: rtl/bch_gen_rom.sv
module bch_gen_rom
    import bch_enc_pkg::*;
(
    input  logic [IDX_W-1:0] idx_i,
    output logic [MAX_P-1:0] taps_o
);

    logic [MAX_P-1:0] tab_w [NSTR];

    for (genvar k = 0; k < int'(NSTR); k++) begin : g_str
        localparam logic [MAX_P-1:0] TAPS = gen_taps_top(2 * (k + 1));
        assign tab_w[k] = TAPS;
    end

    always_comb begin
        taps_o = '0;
        for (int k = 0; k < int'(NSTR); k++) begin
            if (idx_i == IDX_W'(k)) taps_o = tab_w[k];
        end
    end

endmodule

// File: rtl/bch_rem_step.sv
module bch_rem_step
    import bch_enc_pkg::*;
(
    input  logic [MAX_P-1:0] rem_i,
    input  logic [MAX_P-1:0] taps_i,
    input  logic             din_i,
    output logic [MAX_P-1:0] div_o,
    output logic [MAX_P-1:0] shift_o
);

    logic fb;

    always_comb begin
        fb      = din_i ^ rem_i[MAX_P-1];
        shift_o = {rem_i[MAX_P-2:0], 1'b0};
        div_o   = shift_o ^ (fb ? taps_i : '0);
    end

endmodule

// File: rtl/bch_encoder.sv
module bch_encoder
    import bch_enc_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [T_W-1:0]   cfg_t_i,
    input  logic [LEN_W-1:0] cfg_len_i,
    input  logic             in_valid_i,
    input  logic             in_bit_i,
    output logic             in_ready_o,
    output logic             out_valid_o,
    output logic             out_bit_o,
    output logic             out_last_o,
    output logic             busy_o,
    output logic             err_o
);

    enc_regs_t q, d;

    logic              cfg_ok;
    logic [IDX_W-1:0]  cfg_idx;
    logic [PCNT_W-1:0] cfg_plen;
    logic [MAX_P-1:0]  taps;
    logic [MAX_P-1:0]  rem_div;
    logic [MAX_P-1:0]  rem_shift;

    bch_cfg_check u_cfg (
        .cfg_t_i   (cfg_t_i),
        .cfg_len_i (cfg_len_i),
        .ok_o      (cfg_ok),
        .idx_o     (cfg_idx),
        .plen_o    (cfg_plen)
    );

    bch_gen_rom u_rom (
        .idx_i  (q.idx),
        .taps_o (taps)
    );

    bch_rem_step u_step (
        .rem_i   (q.rem),
        .taps_i  (taps),
        .din_i   (in_bit_i),
        .div_o   (rem_div),
        .shift_o (rem_shift)
    );

    always_comb begin
        d         = q;
        d.out_vld = 1'b0;
        d.out_dat = 1'b0;
        d.out_end = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (cfg_ok) begin
                        d.st   = ST_DATA;
                        d.idx  = cfg_idx;
                        d.dcnt = cfg_len_i;
                        d.pcnt = cfg_plen;
                        d.rem  = '0;
                        d.err  = 1'b0;
                    end else begin
                        d.err  = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (in_valid_i) begin
                    d.rem     = rem_div;
                    d.out_vld = 1'b1;
                    d.out_dat = in_bit_i;
                    d.dcnt    = q.dcnt - LEN_W'(1);
                    if (q.dcnt == LEN_W'(1)) d.st = ST_PAR;
                end
            end
            ST_PAR: begin
                d.rem     = rem_shift;
                d.out_vld = 1'b1;
                d.out_dat = q.rem[MAX_P-1];
                d.pcnt    = q.pcnt - PCNT_W'(1);
                if (q.pcnt == PCNT_W'(1)) begin
                    d.out_end = 1'b1;
                    d.st      = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign in_ready_o  = (q.st == ST_DATA);
    assign busy_o      = (q.st != ST_IDLE);
    assign out_valid_o = q.out_vld;
    assign out_bit_o   = q.out_dat;
    assign out_last_o  = q.out_end;
    assign err_o       = q.err;

endmodule

// File: rtl/bch_encoder_chk.sv
module bch_encoder_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic start_i,
    input logic in_valid_i,
    input logic in_bit_i,
    input logic in_ready_o,
    input logic out_valid_o,
    input logic out_bit_o,
    input logic out_last_o,
    input logic busy_o,
    input logic err_o
);

    AST_ERR_WHILE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |-> !busy_o); // R1

    AST_START_RESOLVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && !busy_o) |=> (busy_o != err_o)); // R3

    AST_DATA_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && in_ready_o) |=> (out_valid_o && (out_bit_o == $past(in_bit_i)))); // R4

    AST_LAST_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_last_o |-> (out_valid_o && !busy_o)); // R6

    AST_PARITY_UNBROKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !in_ready_o && out_valid_o && !out_last_o) |=> out_valid_o); // R6

    AST_IDLE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |=> !out_valid_o); // R7

    AST_RESTART_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (start_i && in_ready_o) |=> busy_o); // R8

endmodule

bind bch_encoder bch_encoder_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .in_valid_i  (in_valid_i),
    .in_bit_i    (in_bit_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_bit_o   (out_bit_o),
    .out_last_o  (out_last_o),
    .busy_o      (busy_o),
    .err_o       (err_o)
);

// File: tb/bch_encoder_tb_top.sv
module bch_encoder_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CLK_PERIOD_NS = 10;
    localparam int WATCHDOG      = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [4:0]  cfg_t;
    logic [12:0] cfg_len;
    logic        in_valid;
    logic        in_bit;
    logic        in_ready, out_valid, out_bit, out_last, busy, err;

    always #(CLK_PERIOD_NS / 2) clk = ~clk;

    bch_encoder dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .cfg_t_i     (cfg_t),
        .cfg_len_i   (cfg_len),
        .in_valid_i  (in_valid),
        .in_bit_i    (in_bit),
        .in_ready_o  (in_ready),
        .out_valid_o (out_valid),
        .out_bit_o   (out_bit),
        .out_last_o  (out_last),
        .busy_o      (busy),
        .err_o       (err)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int exp_tab [8191];
    int log_tab [8192];
    logic [260:0] gen_tab [21];

    typedef struct { bit b; bit last; bit par; } exp_t;
    exp_t exp_q[$];
    int   blk_t_q[$];
    bit   cw_q[$];
    bit   par_open = 0;

    task automatic chk(bit ok, string req, string what, longint got, longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, got, expv);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Log/antilog multiply over GF(2^13) with x^13+x^4+x^3+x+1
    function automatic int gmul(int a, int b);
        if (a == 0 || b == 0) return 0;
        return exp_tab[(log_tab[a] + log_tab[b]) % 8191];
    endfunction

    // Generator built directly from its roots (union of conjugate sets)
    function automatic logic [260:0] root_gen(int t);
        int roots[$];
        int c [261];
        int deg;
        logic [260:0] g;
        for (int i = 1; i <= 2 * t; i++) begin
            int e;
            e = i;
            for (int j = 0; j < 13; j++) begin
                bit seen;
                seen = 0;
                foreach (roots[r]) if (roots[r] == e) seen = 1;
                if (!seen) roots.push_back(e);
                e = (e * 2) % 8191;
            end
        end
        foreach (c[k]) c[k] = 0;
        c[0] = 1;
        deg  = 0;
        foreach (roots[r]) begin
            int a;
            a = exp_tab[roots[r]];
            for (int k = deg + 1; k >= 1; k--) c[k] = c[k-1] ^ gmul(a, c[k]);
            c[0] = gmul(a, c[0]);
            deg++;
        end
        g = '0;
        for (int k = 0; k < 261; k++) g[k] = (c[k] != 0);
        return g;
    endfunction

    // Output monitor: every codeword bit compared against the model stream
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_last && !out_valid) chk(0, "R6", "last without valid", 1, 0);
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R7", "unexpected output bit", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(out_bit == e.b, e.par ? "R5" : "R4", "codeword bit", out_bit, e.b);
                    chk(out_last == e.last, "R6", "last marker", out_last, e.last);
                    cw_q.push_back(out_bit);
                    par_open = e.par && !e.last;
                    if (e.last) begin
                        int t;
                        bit zero;
                        t    = blk_t_q.pop_front();
                        zero = 1;
                        for (int i = 1; i <= 2 * t; i++) begin
                            int s;
                            s = 0;
                            foreach (cw_q[k]) s = gmul(s, exp_tab[i]) ^ int'(cw_q[k]);
                            if (s != 0) zero = 0;
                        end
                        chk(zero, "R9", "codeword syndromes zero", zero, 1);
                        cw_q.delete();
                    end
                end
            end else begin
                if (par_open) chk(0, "R6", "gap inside parity", 0, 1);
                par_open = 0;
            end
        end
    end

    task automatic reject(int t, int len, string req);
        start = 1; cfg_t = 5'(t); cfg_len = 13'(len);
        @(negedge clk);
        start = 0;
        chk(err == 1'b1, req, "err after refused start", err, 1);
        chk(busy == 1'b0, req, "busy after refused start", busy, 0);
        chk(in_ready == 1'b0, req, "ready after refused start", in_ready, 0);
    endtask

    // Called at a negedge; returns at the negedge where the last bit is visible
    task automatic send_block(int t, int len, bit gaps, bit poke);
        bit data[];
        bit dv[];
        int p;
        int idx;
        logic [260:0] g;
        p = 13 * t;
        g = gen_tab[t];
        data = new[len];
        dv   = new[len + p];
        foreach (data[i]) data[i] = 1'($urandom);
        foreach (dv[i]) dv[i] = (i < len) ? data[i] : 1'b0;
        for (int i = 0; i < len; i++) begin
            if (dv[i]) for (int j = 0; j <= p; j++) dv[i+j] = dv[i+j] ^ g[p-j];
        end
        for (int i = 0; i < len; i++) exp_q.push_back('{b: data[i], last: 0, par: 0});
        for (int i = 0; i < p; i++) exp_q.push_back('{b: dv[len+i], last: (i == p - 1), par: 1});
        blk_t_q.push_back(t);

        start = 1; cfg_t = 5'(t); cfg_len = 13'(len);
        @(negedge clk);
        start = 0;
        chk(busy == 1'b1, "R3", "busy after accepted start", busy, 1);
        chk(in_ready == 1'b1, "R3", "ready after accepted start", in_ready, 1);
        chk(err == 1'b0, "R3", "err after accepted start", err, 0);

        idx = 0;
        while (idx < len) begin
            bit acc;
            start = 0;
            if (poke && idx == len / 2) begin
                start = 1; cfg_t = 5'd2; cfg_len = 13'd3;
            end
            if (gaps && ($urandom % 4 == 0)) begin
                in_valid = 0; in_bit = 1'($urandom);
            end else begin
                in_valid = 1; in_bit = data[idx];
            end
            acc = in_valid && in_ready;
            @(negedge clk);
            if (start) chk(busy == 1'b1, "R8", "busy after start inside block", busy, 1);
            if (acc) begin
                chk(out_valid == 1'b1, "R4", "echo valid", out_valid, 1);
                idx++;
            end
        end
        start = 0;
        while (busy) begin
            in_valid = 1; in_bit = 1'($urandom);
            chk(in_ready == 1'b0, "R7", "ready during parity", in_ready, 0);
            @(negedge clk);
        end
        in_valid = 0;
    endtask

    initial begin
        int x;
        x = 1;
        for (int i = 0; i < 8191; i++) begin
            exp_tab[i] = x;
            log_tab[x] = i;
            x = x << 1;
            if ((x & 8192) != 0) x = x ^ 'h201B;
        end
        for (int t = 2; t <= 20; t += 2) gen_tab[t] = root_gen(t);

        rst_n = 0; start = 0; cfg_t = 0; cfg_len = 0; in_valid = 0; in_bit = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(busy == 0, "R11", "busy after reset", busy, 0);
        chk(in_ready == 0, "R11", "ready after reset", in_ready, 0);
        chk(out_valid == 0, "R11", "valid after reset", out_valid, 0);
        chk(out_last == 0, "R11", "last after reset", out_last, 0);
        chk(err == 0, "R11", "err after reset", err, 0);

        for (int i = 0; i < 4; i++) begin
            in_valid = 1; in_bit = 1'($urandom);
            @(negedge clk);
        end
        in_valid = 0;
        @(negedge clk);
        chk(out_valid == 0, "R7", "output while idle", out_valid, 0);

        reject(3, 40, "R1");
        reject(0, 40, "R1");
        reject(22, 40, "R1");
        reject(8, 0, "R2");
        reject(20, 7932, "R2");

        send_block(2, 37, 1, 0);
        for (int t = 4; t <= 20; t += 2) send_block(t, 20 + t, (t % 4) == 0, 0);
        send_block(10, 50, 1, 1);
        send_block(8, 4096, 0, 0);
        send_block(20, 7931, 0, 0);
        chk(out_last == 1'b1, "R10", "last visible when restarting", out_last, 1);
        send_block(6, 30, 1, 0);
        chk(out_last == 1'b1, "R10", "last visible when restarting", out_last, 1);
        send_block(4, 25, 0, 1);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "bits still expected", exp_q.size(), 0);
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R6: watchdog cycles got %0d expected fewer", WATCHDOG);
            finish_run();
        end
    end

endmodule